// File: doc/BRIEF.md
# Machine Check Error Bank Logger

This block holds a set of machine-check reporting banks and decides, for every injected error record, what happens to it. An injection carries a bank number, a bank status word, a global status word, an address word, a misc word and an "unconditional" flag. The block also watches a machine-check enable input taken from the control state of the core. From these inputs and its own registers it rejects, ignores, drops, logs or overflow-marks the record, or asks for a reset. A logged uncorrected error also raises a one-cycle machine-check interrupt.

Each bank has four 64-bit registers: control, status, address and misc. Three global registers sit beside them: capability (bank count in bits 7:0, control-present flag in bit 8), global control and global status. Software reads and writes all of them through a flat register port with a combinational read. The decision takes one cycle, and its result code appears on the outputs on the clock edge that follows the request.

Top module: `mca_bank_logger`

## Requirements
- R1: After reset every bank control register reads all ones, every bank status, address and misc register reads zero, global control reads all ones, global status reads zero, capability reads (CTL_PRESENT<<8)|NUM_BANKS, and res_valid, mce_irq and reset_req are low.
- R2: A request gets code 1 (rejected) and changes no register when capability is zero, when the bank number is not below capability bits 7:0 or not below NUM_BANKS, or when status bit 63 (valid) is clear.
- R3: A valid request gets code 2 (ignored) and changes no register when status bit 55 (action required) is clear, global status bit 2 (in progress) is set and the unconditional flag is clear.
- R4: An uncorrected request (status bit 61 set) gets code 3 (dropped) and changes nothing when capability bit 8 is set and global control is not all ones, or when the bank's control register is not all ones.
- R5: An uncorrected request that passes R4 gets code 4 and a one-cycle reset_req pulse, and changes nothing, when mce_enable is low or global status bit 2 is set.
- R6: Any other uncorrected request gets code 5 (logged): the bank takes the new status, with bit 62 (overflow) also set if the bank's old status had bit 63 set, plus the address and misc words; global status takes the request's global status word; mce_irq pulses for one cycle.
- R7: A corrected request (bit 61 clear) to a bank whose status has bit 63 clear or bit 61 clear gets code 5: status, address and misc are overwritten, bit 62 is set in the new status if the old status had bit 63 set, global status is unchanged and no interrupt is raised.
- R8: A corrected request to a bank that holds a valid uncorrected record gets code 6 (overflow marked): only bit 62 of that bank's status is set and the other registers keep their contents.
- R9: res_valid, res_code, mce_irq and reset_req are registered. res_valid is high exactly in the cycle after a cycle with inj_valid high. mce_irq and reset_req are never high together.
- R10: Register addresses: 0 capability, 1 global status, 2 global control, 3 reads zero; bank b occupies 4+4b (control), 5+4b (status), 6+4b (address) and 7+4b (misc). A write with reg_we high lands on the next edge, and reg_rdata shows the addressed register in the same cycle.
- R11: When an injection and a register write fall in the same cycle, the decision uses the register values from before that edge. If both update the same register the injection's value is kept; a write to any other register lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inj_valid | input | 1 | Injection request this cycle |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | DATA_W | New bank status word |
| inj_gstatus | input | DATA_W | New global status word |
| inj_addr | input | DATA_W | Error address word |
| inj_misc | input | DATA_W | Error misc word |
| inj_uncond | input | 1 | Deliver even while a machine check is in progress |
| mce_enable | input | 1 | Machine-check exception enable of the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| res_valid | output | 1 | Result code valid |
| res_code | output | 3 | Result of the previous cycle's injection |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset request pulse |

## Verification
The two functions that can fall in one cycle are an injection and a software register write. The bench drives both on the same clock edge in two ways. In the first, the write targets the address register that the logged injection also fills, and the bench expects the injection's address to remain. In the second, the write clears global control while an uncorrected error is injected, and the bench expects the error to be logged, because the decision uses the old control value, and global control to read zero afterwards. Random runs mix writes to the control and status registers with injections, so that drops, ignores and resets follow from states that software has built up.

// File: rtl/mcbl_pkg.sv
package mcbl_pkg;
   localparam int ST_VAL   = 63;
   localparam int ST_OVER  = 62;
   localparam int ST_UC    = 61;
   localparam int ST_AR    = 55;
   localparam int GS_MCIP  = 2;
   localparam int CAP_CTLP = 8;

   typedef enum logic [2:0] {
      RC_NONE   = 3'd0,
      RC_REJECT = 3'd1,
      RC_IGNORE = 3'd2,
      RC_DROP   = 3'd3,
      RC_RESET  = 3'd4,
      RC_LOGGED = 3'd5,
      RC_MARKED = 3'd6
   } res_code_e;

   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_FULL = 2'd1,
      UPD_OVER = 2'd2
   } bank_upd_e;

   typedef struct packed {
      res_code_e code;
      bank_upd_e upd;
      logic      wr_gstat;
      logic      irq;
      logic      rst;
   } verdict_t;
endpackage

// File: rtl/mcbl_decide.sv
module mcbl_decide
   import mcbl_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int NUM_BANKS = 4
) (
   input  logic [DATA_W-1:0] cap,
   input  logic [DATA_W-1:0] gctl,
   input  logic [DATA_W-1:0] gstat,
   input  logic [7:0]        bank_num,
   input  logic [DATA_W-1:0] req_status,
   input  logic              req_uncond,
   input  logic              mce_enable,
   input  logic              in_range,
   input  logic [DATA_W-1:0] sel_ctl,
   input  logic [DATA_W-1:0] sel_status,
   output verdict_t          verdict,
   output logic [DATA_W-1:0] new_status
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   logic req_ok, mcip, ar, uc, ctl_block, old_valid, old_uc;

   always_comb begin
      req_ok    = (cap != '0) && (bank_num < cap[7:0]) && in_range && req_status[ST_VAL];
      mcip      = gstat[GS_MCIP];
      ar        = req_status[ST_AR];
      uc        = req_status[ST_UC];
      ctl_block = (cap[CAP_CTLP] && (gctl != ALL_ONES)) || (sel_ctl != ALL_ONES);
      old_valid = sel_status[ST_VAL];
      old_uc    = sel_status[ST_UC];
   end

   always_comb begin
      verdict    = '{code: RC_REJECT, upd: UPD_NONE, wr_gstat: 1'b0, irq: 1'b0, rst: 1'b0};
      new_status = req_status;
      new_status[ST_OVER] = req_status[ST_OVER] | old_valid;
      if (!req_ok) begin
         verdict.code = RC_REJECT;
      end else if (!req_uncond && !ar && mcip) begin
         verdict.code = RC_IGNORE;
      end else if (uc) begin
         if (ctl_block) begin
            verdict.code = RC_DROP;
         end else if (!mce_enable || mcip) begin
            verdict.code = RC_RESET;
            verdict.rst  = 1'b1;
         end else begin
            verdict.code     = RC_LOGGED;
            verdict.upd      = UPD_FULL;
            verdict.wr_gstat = 1'b1;
            verdict.irq      = 1'b1;
         end
      end else if (!old_valid || !old_uc) begin
         verdict.code = RC_LOGGED;
         verdict.upd  = UPD_FULL;
      end else begin
         verdict.code = RC_MARKED;
         verdict.upd  = UPD_OVER;
      end
   end
endmodule

// File: rtl/mcbl_bank.sv
module mcbl_bank
   import mcbl_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        sw_we,
   input  logic [DATA_W-1:0] sw_wdata,
   input  bank_upd_e         upd,
   input  logic [DATA_W-1:0] upd_status,
   input  logic [DATA_W-1:0] upd_addr,
   input  logic [DATA_W-1:0] upd_misc,
   output logic [DATA_W-1:0] ctl,
   output logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] misc
);
   localparam logic [DATA_W-1:0] OVER_MASK = DATA_W'(1) << ST_OVER;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '1;
         status <= '0;
         addr   <= '0;
         misc   <= '0;
      end else begin
         if (sw_we[0]) ctl <= sw_wdata;
         if (upd == UPD_FULL)      status <= upd_status;
         else if (upd == UPD_OVER) status <= status | OVER_MASK;
         else if (sw_we[1])        status <= sw_wdata;
         if (upd == UPD_FULL)      addr <= upd_addr;
         else if (sw_we[2])        addr <= sw_wdata;
         if (upd == UPD_FULL)      misc <= upd_misc;
         else if (sw_we[3])        misc <= sw_wdata;
      end
   end
endmodule

// File: rtl/mcbl_global.sv
module mcbl_global #(
   parameter int                 DATA_W    = 64,
   parameter logic [DATA_W-1:0]  CAP_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sw_we,
   input  logic [DATA_W-1:0] sw_wdata,
   input  logic              gstat_upd,
   input  logic [DATA_W-1:0] gstat_new,
   output logic [DATA_W-1:0] cap,
   output logic [DATA_W-1:0] gstat,
   output logic [DATA_W-1:0] gctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap   <= CAP_RESET;
         gstat <= '0;
         gctl  <= '1;
      end else begin
         if (sw_we[0]) cap <= sw_wdata;
         if (gstat_upd)      gstat <= gstat_new;
         else if (sw_we[1])  gstat <= sw_wdata;
         if (sw_we[2]) gctl <= sw_wdata;
      end
   end
endmodule

// File: rtl/mca_bank_logger.sv
module mca_bank_logger
   import mcbl_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int NUM_BANKS   = 4,
   parameter bit CTL_PRESENT = 1'b1,
   parameter bit READ_REG    = 1'b0,
   localparam int NREGS      = 4 + 4 * NUM_BANKS,
   localparam int ADDR_W     = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inj_valid,
   input  logic [7:0]        inj_bank,
   input  logic [DATA_W-1:0] inj_status,
   input  logic [DATA_W-1:0] inj_gstatus,
   input  logic [DATA_W-1:0] inj_addr,
   input  logic [DATA_W-1:0] inj_misc,
   input  logic              inj_uncond,
   input  logic              mce_enable,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              res_valid,
   output logic [2:0]        res_code,
   output logic              mce_irq,
   output logic              reset_req
);
   localparam int BLK_W = ADDR_W - 2;
   localparam logic [DATA_W-1:0] CAP_RESET =
      DATA_W'((CTL_PRESENT ? 256 : 0) + NUM_BANKS);

   if (DATA_W < 64) begin : g_bad_width
      $error("DATA_W must be at least 64 to hold the status fields");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 255) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..255");
   end

   logic [DATA_W-1:0] b_ctl  [NUM_BANKS];
   logic [DATA_W-1:0] b_stat [NUM_BANKS];
   logic [DATA_W-1:0] b_addr [NUM_BANKS];
   logic [DATA_W-1:0] b_misc [NUM_BANKS];
   logic [DATA_W-1:0] cap, gstat, gctl;

   logic [BLK_W-1:0] blk_idx;
   logic [1:0]       field;
   logic [3:0]       field_we;
   assign blk_idx  = reg_addr[ADDR_W-1:2];
   assign field    = reg_addr[1:0];
   assign field_we = reg_we ? (4'b0001 << field) : 4'b0000;

   // selected bank for the injection
   logic              in_range;
   logic [DATA_W-1:0] sel_ctl, sel_status;
   assign in_range = 32'(inj_bank) < 32'(NUM_BANKS);

   always_comb begin
      sel_ctl    = '0;
      sel_status = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (32'(inj_bank) == i) begin
            sel_ctl    = b_ctl[i];
            sel_status = b_stat[i];
         end
      end
   end

   verdict_t          verdict;
   logic [DATA_W-1:0] new_status;

   mcbl_decide #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_decide (
      .cap        (cap),
      .gctl       (gctl),
      .gstat      (gstat),
      .bank_num   (inj_bank),
      .req_status (inj_status),
      .req_uncond (inj_uncond),
      .mce_enable (mce_enable),
      .in_range   (in_range),
      .sel_ctl    (sel_ctl),
      .sel_status (sel_status),
      .verdict    (verdict),
      .new_status (new_status)
   );

   mcbl_global #(.DATA_W(DATA_W), .CAP_RESET(CAP_RESET)) u_global (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     ((blk_idx == '0) ? field_we[2:0] : 3'b000),
      .sw_wdata  (reg_wdata),
      .gstat_upd (inj_valid && verdict.wr_gstat),
      .gstat_new (inj_gstatus),
      .cap       (cap),
      .gstat     (gstat),
      .gctl      (gctl)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic      hit_sw;
      bank_upd_e upd_b;
      assign hit_sw = 32'(blk_idx) == b + 1;
      assign upd_b  = (inj_valid && in_range && 32'(inj_bank) == b) ? verdict.upd : UPD_NONE;

      mcbl_bank #(.DATA_W(DATA_W)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .sw_we      (hit_sw ? field_we : 4'b0000),
         .sw_wdata   (reg_wdata),
         .upd        (upd_b),
         .upd_status (new_status),
         .upd_addr   (inj_addr),
         .upd_misc   (inj_misc),
         .ctl        (b_ctl[b]),
         .status     (b_stat[b]),
         .addr       (b_addr[b]),
         .misc       (b_misc[b])
      );
   end

   // read mux
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (blk_idx == '0) begin
         case (field)
            2'd0:    rd_mux = cap;
            2'd1:    rd_mux = gstat;
            2'd2:    rd_mux = gctl;
            default: rd_mux = '0;
         endcase
      end else begin
         for (int i = 0; i < NUM_BANKS; i++) begin
            if (32'(blk_idx) == i + 1) begin
               case (field)
                  2'd0:    rd_mux = b_ctl[i];
                  2'd1:    rd_mux = b_stat[i];
                  2'd2:    rd_mux = b_addr[i];
                  default: rd_mux = b_misc[i];
               endcase
            end
         end
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) reg_rdata <= '0;
         else        reg_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end

   // registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_code  <= RC_NONE;
         mce_irq   <= 1'b0;
         reset_req <= 1'b0;
      end else begin
         res_valid <= inj_valid;
         res_code  <= inj_valid ? verdict.code : RC_NONE;
         mce_irq   <= inj_valid && verdict.irq;
         reset_req <= inj_valid && verdict.rst;
      end
   end
endmodule

// File: rtl/mcbl_checker.sv
module mcbl_checker
   import mcbl_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inj_valid,
   input logic [DATA_W-1:0] inj_status,
   input logic              res_valid,
   input logic [2:0]        res_code,
   input logic              mce_irq,
   input logic              reset_req
);
   a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      inj_valid |=> res_valid);
   a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_valid |=> !res_valid);
   a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mce_irq && reset_req));
   a_r6_irq_with_log: assert property (@(posedge clk) disable iff (!rst_n)
      mce_irq |-> (res_valid && res_code == RC_LOGGED));
   a_r5_reset_with_code: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (res_valid && res_code == RC_RESET));
   a_r2_reject_no_val: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_valid && !inj_status[ST_VAL]) |=> (res_code == RC_REJECT));
endmodule

bind mca_bank_logger mcbl_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .inj_valid  (inj_valid),
   .inj_status (inj_status),
   .res_valid  (res_valid),
   .res_code   (res_code),
   .mce_irq    (mce_irq),
   .reset_req  (reset_req)
);

// File: tb/mca_bank_logger_test.sv
module mca_bank_logger_test;
   localparam int PERIOD = 10;
   localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
   localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
   localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
   localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
   localparam logic [63:0] MCIP = 64'h4;
   localparam logic [63:0] ONES = '1;

   logic clk = 0, rst_n = 0;
   logic inj_valid = 0, inj_uncond = 0, mce_enable = 1, reg_we = 0;
   logic [7:0]  inj_bank = 0;
   logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0, reg_wdata = 0;
   logic [4:0]  reg_addr = 0;
   logic [63:0] reg_rdata;
   logic        res_valid, mce_irq, reset_req;
   logic [2:0]  res_code;

   int checks = 0, errors = 0;
   logic [63:0] m_cap, m_gctl, m_gstat, rv;
   logic [63:0] m_ctl [4], m_st [4], m_ad [4], m_mi [4];

   always #(PERIOD/2) clk = ~clk;

   mca_bank_logger uut (
      .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_bank(inj_bank),
      .inj_status(inj_status), .inj_gstatus(inj_gstatus), .inj_addr(inj_addr),
      .inj_misc(inj_misc), .inj_uncond(inj_uncond), .mce_enable(mce_enable),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .res_valid(res_valid), .res_code(res_code),
      .mce_irq(mce_irq), .reset_req(reset_req));

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic rd(int a);
      reg_addr = 5'(a);
      #1 rv = reg_rdata;
   endtask

   function automatic logic [2:0] exp_code(int b, logic [63:0] st, logic unc, logic cr);
      if (m_cap == 0 || b >= int'(m_cap[7:0]) || b >= 4 || !st[63]) return 3'd1;
      if (!unc && !st[55] && m_gstat[2]) return 3'd2;
      if (st[61]) begin
         if ((m_cap[8] && m_gctl != ONES) || m_ctl[b] != ONES) return 3'd3;
         if (!cr || m_gstat[2]) return 3'd4;
         return 3'd5;
      end
      if (!m_st[b][63] || !m_st[b][61]) return 3'd5;
      return 3'd6;
   endfunction

   task automatic model_write(int a, logic [63:0] d);
      if (a == 0) m_cap = d;
      else if (a == 1) m_gstat = d;
      else if (a == 2) m_gctl = d;
      else if (a >= 4) begin
         case (a % 4)
            0: m_ctl[(a-4)/4] = d;
            1: m_st[(a-4)/4]  = d;
            2: m_ad[(a-4)/4]  = d;
            default: m_mi[(a-4)/4] = d;
         endcase
      end
   endtask

   task automatic model_apply(int b, logic [2:0] ec, logic [63:0] st, gs, ad, mi);
      if (ec == 3'd5) begin
         m_st[b] = st | (m_st[b][63] ? OVR : 64'd0);
         m_ad[b] = ad;
         m_mi[b] = mi;
         if (st[61]) m_gstat = gs;
      end else if (ec == 3'd6) begin
         m_st[b] = m_st[b] | OVR;
      end
   endtask

   task automatic wr(int a, logic [63:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
      model_write(a, d);
   endtask

   task automatic check_state(int b, string rq);
      rd(1); chk(rq, "gstatus", rv, m_gstat);
      if (b < 4) begin
         rd(5 + 4*b); chk(rq, "bank status", rv, m_st[b]);
         rd(6 + 4*b); chk(rq, "bank addr", rv, m_ad[b]);
         rd(7 + 4*b); chk(rq, "bank misc", rv, m_mi[b]);
      end
   endtask

   task automatic inject(int b, logic [63:0] st, gs, ad, mi, logic unc, logic cr, string rq);
      logic [2:0] ec;
      ec = exp_code(b, st, unc, cr);
      @(negedge clk);
      inj_valid = 1; inj_bank = 8'(b); inj_status = st; inj_gstatus = gs;
      inj_addr = ad; inj_misc = mi; inj_uncond = unc; mce_enable = cr;
      @(negedge clk);
      inj_valid = 0;
      chk(rq, "res_valid", 64'(res_valid), 64'd1);
      chk(rq, "res_code", 64'(res_code), 64'(ec));
      chk(rq, "mce_irq", 64'(mce_irq), 64'(ec == 3'd5 && st[61]));
      chk(rq, "reset_req", 64'(reset_req), 64'(ec == 3'd4));
      model_apply(b, ec, st, gs, ad, mi);
      check_state(b, rq);
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      m_cap = 64'h104; m_gctl = ONES; m_gstat = 0;
      for (int i = 0; i < 4; i++) begin
         m_ctl[i] = ONES; m_st[i] = 0; m_ad[i] = 0; m_mi[i] = 0;
      end
      #(PERIOD*3) rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(0);  chk("R1", "cap", rv, 64'h104);
      rd(2);  chk("R1", "gctl", rv, ONES);
      rd(1);  chk("R1", "gstat", rv, 64'd0);
      rd(4);  chk("R1", "bank0 ctl", rv, ONES);
      rd(17); chk("R1", "bank3 status", rv, 64'd0);
      rd(19); chk("R1", "bank3 misc", rv, 64'd0);
      chk("R1", "res_valid", 64'(res_valid), 64'd0);
      chk("R1", "irq/reset", 64'({mce_irq, reset_req}), 64'd0);

      // R2 reject cases
      inject(0, 64'h11, 0, 64'hA0, 64'hB0, 0, 1, "R2");
      inject(4, VAL | UC, 0, 64'hA1, 64'hB1, 0, 1, "R2");
      wr(0, 64'h0);
      inject(0, VAL, 0, 64'hA2, 64'hB2, 0, 1, "R2");
      wr(0, 64'h102);
      inject(2, VAL, 0, 64'hA3, 64'hB3, 0, 1, "R2");
      wr(0, 64'h104);
      // R10 register port write/read
      wr(18, 64'h1234_5678); rd(18); chk("R10", "bank3 addr", rv, 64'h1234_5678);
      rd(3); chk("R10", "reserved", rv, 64'd0);
      wr(18, 64'd0);

      // R7 corrected into empty, then into corrected
      inject(0, VAL | 64'h5, 0, 64'hC0, 64'hD0, 0, 1, "R7");
      inject(0, VAL | 64'h6, 0, 64'hC1, 64'hD1, 0, 1, "R7");
      // R6 uncorrected log, sets MCIP
      inject(1, VAL | UC | AR, MCIP | 64'h1, 64'hE0, 64'hF0, 0, 1, "R6");
      // R5 uncorrected while MCIP set
      inject(2, VAL | UC | AR, 0, 64'hE1, 64'hF1, 0, 1, "R5");
      // R3 ignore, then unconditional delivery
      inject(2, VAL | 64'h9, 0, 64'hE2, 64'hF2, 0, 1, "R3");
      inject(2, VAL | 64'h9, 0, 64'hE3, 64'hF3, 1, 1, "R3");
      // R8 corrected into bank holding uncorrected record
      inject(1, VAL | AR | 64'h7, 0, 64'hE4, 64'hF4, 0, 1, "R8");
      // R5 enable low
      wr(1, 64'd0);
      inject(3, VAL | UC | AR, 0, 64'hE5, 64'hF5, 0, 0, "R5");
      // R4 drops
      wr(16, 64'hF);
      inject(3, VAL | UC | AR, 0, 64'hE6, 64'hF6, 0, 1, "R4");
      wr(16, ONES);
      wr(2, 64'hFFFF);
      inject(3, VAL | UC | AR, 0, 64'hE7, 64'hF7, 0, 1, "R4");
      wr(2, ONES);
      // R6 uncorrected overflow onto valid record
      inject(0, VAL | UC, 64'h1, 64'hE8, 64'hF8, 0, 1, "R6");

      // R11 collision: injection and write to same address register
      wr(5, 0); wr(9, 0); wr(1, 0);
      @(negedge clk);
      inj_valid = 1; inj_bank = 0; inj_status = VAL | UC | AR; inj_gstatus = 64'h10;
      inj_addr = 64'hAAAA; inj_misc = 64'hBBBB; inj_uncond = 0; mce_enable = 1;
      reg_we = 1; reg_addr = 5'd6; reg_wdata = 64'h5555;
      @(negedge clk);
      inj_valid = 0; reg_we = 0;
      chk("R11", "res_code", 64'(res_code), 64'd5);
      chk("R11", "mce_irq", 64'(mce_irq), 64'd1);
      model_apply(0, 3'd5, VAL | UC | AR, 64'h10, 64'hAAAA, 64'hBBBB);
      check_state(0, "R11");
      // R11 collision: global control cleared in the same cycle
      @(negedge clk);
      inj_valid = 1; inj_bank = 1; inj_status = VAL | UC | AR; inj_gstatus = 64'h20;
      inj_addr = 64'hCCCC; inj_misc = 64'hDDDD;
      reg_we = 1; reg_addr = 5'd2; reg_wdata = 64'd0;
      @(negedge clk);
      inj_valid = 0; reg_we = 0;
      chk("R11", "res_code", 64'(res_code), 64'd5);
      model_apply(1, 3'd5, VAL | UC | AR, 64'h20, 64'hCCCC, 64'hDDDD);
      model_write(2, 64'd0);
      check_state(1, "R11");
      rd(2); chk("R11", "gctl after", rv, 64'd0);
      wr(2, ONES);

      // random mix, R2..R8
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom % 6);
         if (op == 0) begin
            int k;
            k = int'($urandom % 4);
            if (k == 0)      wr(1, ($urandom % 2) ? MCIP : 64'd0);
            else if (k == 1) wr(2, ($urandom % 4 != 0) ? ONES : 64'hFF);
            else if (k == 2) wr(4 + 4*int'($urandom % 4), ($urandom % 4 != 0) ? ONES : 64'h3);
            else             wr(5 + 4*int'($urandom % 4), 64'd0);
         end else begin
            int b;
            logic [63:0] st, gs;
            b  = int'($urandom % 6);
            st = {32'd0, $urandom};
            st[63] = ($urandom % 8) != 0;
            st[62] = 1'b0;
            st[61] = $urandom % 2;
            st[55] = $urandom % 2;
            gs = ($urandom % 2) ? MCIP : 64'h1;
            inject(b, st, gs, {32'd0, $urandom}, {32'd0, $urandom},
                   ($urandom % 4) == 0, ($urandom % 8) != 0, "R2-R8 random");
         end
      end

      @(negedge clk);
      chk("R9", "res_valid idle", 64'(res_valid), 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule